// File: doc/BRIEF.md
# Multiplane Flash Program and Erase Engine

This block performs the write side of a small NAND-style flash array that is split into four planes. A command front-end hands it decoded command bytes, the assembled page number and low column byte, and the bytes of a page-sized write buffer. The engine carries out page programming and block erasure directly on an internal byte array. It can stage work for several planes and then perform all of it in one commit.

Programming can only clear bits: every stored byte becomes the old byte ANDed with the source byte. An erase returns all bytes of a 32-page block to 0xFF. Staging uses a per-plane slot, holding a page copy and an address, together with a pending-plane mask. The final program or erase command drains that mask. A bad-block bitmap is loaded through its own write port. Any committed plane whose block is marked sets the fail bit of the status byte and a per-plane bit in the multiplane status byte.

A read port onto the array lets the neighbouring read path fetch stored bytes. Reading pages, decoding the host bus and reporting the device ID belong to other blocks.

Top module: `mp_flash_engine`

## Requirements
- R1: After reset the engine is idle and `busy` is 0. `status` and `mp_status` both read 0xC0, `incons` is 0, and the bad-block bitmap is cleared.
- R2: Command 0x10 writes each byte of the page given by `cmd_page` as the old stored byte ANDed with the write-buffer byte at the same index. Bytes outside that page keep their values.
- R3: An erase sets every byte of the 32 pages of the target block to 0xFF. The block number is `cmd_page` shifted right by 5.
- R4: Command 0x11 copies the write buffer into the slot of the plane given by page bits [6:5], records the address there, and sets that plane's pending bit. On a later 0x10, the addressed page is written from the write buffer and its plane bit is dropped. Every other pending plane is then written from its slot, in ascending plane order, and the mask ends empty.
- R5: A 0x60 accepted while the previous accepted command was 0x60 records `cmd_page` in the slot of its plane and sets that plane's pending bit. A 0xD0 accepted right after a 0x60 erases the block of `cmd_page` and then the block of every other pending plane.
- R6: A 0xD0 accepted when the previous command was not 0x60 changes no array byte. It sets the fail bit and clears the pending mask.
- R7: After a program or erase commit, bit p of a 4-bit bad vector is 1 when a committed plane p targets a block marked in the bitmap. The status fail bit (bit 0) is the OR of that vector.
- R8: `status` is {1, ready, 00000, fail}, where ready (bit 6) is low while `busy`. `mp_status` is `status` ORed with the bad vector shifted left by one (bits 4:1).
- R9: A command presented while `busy` is high is ignored and does not count as the previous command.
- R10: On 0x10, `incons` becomes 1 when any other pending plane holds a column byte different from `cmd_col`; otherwise it becomes 0. The commit proceeds in both cases.
- R11: A `bb_we` pulse sets the bitmap entry of block `bb_blk` to `bb_mark`. A block cleared again no longer fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_code | input | 8 | Decoded command byte |
| cmd_page | input | 8 | Assembled page number (block in bits 7:5) |
| cmd_col | input | 8 | Low column byte of the address |
| wb_we | input | 1 | Write-buffer write enable |
| wb_idx | input | 3 | Write-buffer byte index |
| wb_data | input | 8 | Write-buffer byte |
| bb_we | input | 1 | Bad-block bitmap write enable |
| bb_blk | input | 3 | Block index for bitmap write |
| bb_mark | input | 1 | 1 marks the block bad, 0 clears it |
| rd_page | input | 8 | Array read page |
| rd_idx | input | 3 | Array read byte index |
| rd_data | output | 8 | Array byte, one cycle after the address |
| busy | output | 1 | Engine is copying, programming or erasing |
| status | output | 8 | Status byte |
| mp_status | output | 8 | Multiplane status byte |
| incons | output | 1 | Column mismatch seen at the last program commit |

## Verification
The assertions watch, on every cycle, that erase writes only 0xFF, that program writes never set a bit the array held, that the pending mask is empty whenever a commit finishes, and that the fail bit agrees with the per-plane bad vector. They also check that a command arriving while busy leaves the command history alone and that an out-of-order 0xD0 fails without starting work. Only the bench's scenarios can show the stored contents of staged planes, the ANDing across repeated programs, the exact multiplane status values for chosen bad blocks, and the column mismatch flag.

// File: rtl/mpfe_pkg.sv
package mpfe_pkg;
  localparam logic [7:0] OP_PROG        = 8'h10;
  localparam logic [7:0] OP_STAGE       = 8'h11;
  localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
  localparam logic [7:0] OP_ERASE_GO    = 8'hD0;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_COPY,
    ST_PROG,
    ST_ERASE
  } eng_state_e;
endpackage

// File: rtl/mpfe_sdp_ram.sv
module mpfe_sdp_ram #(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mpfe_array_ram.sv
module mpfe_array_ram #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [7:0]    rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [7:0]    rdata_b
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_a <= mem[raddr_a];
  end

  always_ff @(posedge clk) begin
    rdata_b <= mem[raddr_b];
  end
endmodule

// File: rtl/mp_flash_engine.sv
module mp_flash_engine
  import mpfe_pkg::*;
#(
  parameter int PAGE_LOG2  = 3,
  parameter int PPB_LOG2   = 5,
  parameter int BLK_LOG2   = 3,
  parameter int PLANE_LOG2 = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cmd_valid,
  input  logic [7:0]                    cmd_code,
  input  logic [PPB_LOG2+BLK_LOG2-1:0]  cmd_page,
  input  logic [7:0]                    cmd_col,
  input  logic                          wb_we,
  input  logic [PAGE_LOG2-1:0]          wb_idx,
  input  logic [7:0]                    wb_data,
  input  logic                          bb_we,
  input  logic [BLK_LOG2-1:0]           bb_blk,
  input  logic                          bb_mark,
  input  logic [PPB_LOG2+BLK_LOG2-1:0]  rd_page,
  input  logic [PAGE_LOG2-1:0]          rd_idx,
  output logic [7:0]                    rd_data,
  output logic                          busy,
  output logic [7:0]                    status,
  output logic [7:0]                    mp_status,
  output logic                          incons
);
  localparam int PG_W      = PPB_LOG2 + BLK_LOG2;
  localparam int NBLK      = 1 << BLK_LOG2;
  localparam int NPL       = 1 << PLANE_LOG2;
  localparam int PB        = 1 << PAGE_LOG2;
  localparam int BLK_BYTES = 1 << (PPB_LOG2 + PAGE_LOG2);
  localparam int ARR_AW    = PG_W + PAGE_LOG2;
  localparam int SLOT_AW   = PLANE_LOG2 + PAGE_LOG2;
  localparam int CNT_W     = PPB_LOG2 + PAGE_LOG2 + 1;

  eng_state_e             st;
  logic [CNT_W-1:0]       cnt;
  logic [PG_W-1:0]        cur_page;
  logic [PLANE_LOG2-1:0]  cur_pl;
  logic                   src_slot;
  logic [PLANE_LOG2-1:0]  src_pl;
  logic [NPL-1:0]         pend_mask;
  logic [PG_W-1:0]        slot_page [NPL];
  logic [7:0]             slot_col  [NPL];
  logic [7:0]             prev_cmd;
  logic                   fail_q;
  logic [NPL-1:0]         mp_bad;
  logic [NPL-1:0]         bad_acc;
  logic                   incons_q;
  logic [NBLK-1:0]        bb_map;

  // Decoded command address
  logic [PLANE_LOG2-1:0]  cmd_pl;
  logic [BLK_LOG2-1:0]    cmd_blk;
  logic [NPL-1:0]         cmd_oh;
  logic                   cmd_bad;
  logic [NPL-1:0]         col_mis;

  assign cmd_pl  = cmd_page[PPB_LOG2 +: PLANE_LOG2];
  assign cmd_blk = cmd_page[PG_W-1:PPB_LOG2];
  assign cmd_oh  = NPL'(1) << cmd_pl;
  assign cmd_bad = bb_map[cmd_blk];

  for (genvar g = 0; g < NPL; g++) begin : g_colcmp
    assign col_mis[g] = (slot_col[g] != cmd_col);
  end

  // Next pending plane, lowest index first
  logic [PLANE_LOG2-1:0]  nxt_pl;
  logic                   nxt_any;
  logic [NPL-1:0]         nxt_oh;
  logic [PG_W-1:0]        nxt_page;
  logic                   nxt_bad;

  always_comb begin
    nxt_pl  = '0;
    nxt_any = 1'b0;
    for (int j = NPL - 1; j >= 0; j--) begin
      if (pend_mask[j]) begin
        nxt_pl  = PLANE_LOG2'(j);
        nxt_any = 1'b1;
      end
    end
  end

  assign nxt_oh   = NPL'(1) << nxt_pl;
  assign nxt_page = slot_page[nxt_pl];
  assign nxt_bad  = bb_map[nxt_page[PG_W-1:PPB_LOG2]];

  logic                 page_last;
  logic                 erase_last;
  logic [PAGE_LOG2-1:0] idx_lo;
  logic [PAGE_LOG2-1:0] idx_m1;

  assign page_last  = (cnt == CNT_W'(PB));
  assign erase_last = (cnt == CNT_W'(BLK_BYTES - 1));
  assign idx_lo     = cnt[PAGE_LOG2-1:0];
  assign idx_m1     = idx_lo - PAGE_LOG2'(1);

  // Storage
  logic [7:0]         wbuf_rdata;
  logic [7:0]         slot_rdata;
  logic [7:0]         arr_old;
  logic               slot_we;
  logic               arr_we;
  logic [ARR_AW-1:0]  arr_waddr;
  logic [7:0]         arr_wdata;

  assign slot_we   = (st == ST_COPY) && (cnt != '0);
  assign arr_we    = ((st == ST_PROG) && (cnt != '0)) || (st == ST_ERASE);
  assign arr_waddr = (st == ST_ERASE) ? {cur_page[PG_W-1:PPB_LOG2], cnt[PPB_LOG2+PAGE_LOG2-1:0]}
                                      : {cur_page, idx_m1};
  assign arr_wdata = (st == ST_ERASE) ? 8'hFF
                                      : (arr_old & (src_slot ? slot_rdata : wbuf_rdata));

  mpfe_sdp_ram #(.AW(PAGE_LOG2), .DW(8)) u_wbuf (
    .clk(clk), .we(wb_we), .waddr(wb_idx), .wdata(wb_data),
    .raddr(idx_lo), .rdata(wbuf_rdata)
  );

  mpfe_sdp_ram #(.AW(SLOT_AW), .DW(8)) u_slots (
    .clk(clk), .we(slot_we), .waddr({cur_pl, idx_m1}), .wdata(wbuf_rdata),
    .raddr({src_pl, idx_lo}), .rdata(slot_rdata)
  );

  mpfe_array_ram #(.AW(ARR_AW)) u_array (
    .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
    .raddr_a({cur_page, idx_lo}), .rdata_a(arr_old),
    .raddr_b({rd_page, rd_idx}), .rdata_b(rd_data)
  );

  // Control
  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      cur_page  <= '0;
      cur_pl    <= '0;
      src_slot  <= 1'b0;
      src_pl    <= '0;
      pend_mask <= '0;
      prev_cmd  <= '0;
      fail_q    <= 1'b0;
      mp_bad    <= '0;
      bad_acc   <= '0;
      incons_q  <= 1'b0;
      bb_map    <= '0;
      for (int j = 0; j < NPL; j++) begin
        slot_page[j] <= '0;
        slot_col[j]  <= '0;
      end
    end else begin
      if (bb_we) bb_map[bb_blk] <= bb_mark;
      case (st)
        ST_IDLE: begin
          if (cmd_valid) begin
            prev_cmd <= cmd_code;
            case (cmd_code)
              OP_STAGE: begin
                st                <= ST_COPY;
                cnt               <= '0;
                cur_pl            <= cmd_pl;
                slot_page[cmd_pl] <= cmd_page;
                slot_col[cmd_pl]  <= cmd_col;
                pend_mask         <= pend_mask | cmd_oh;
              end
              OP_PROG: begin
                st        <= ST_PROG;
                cnt       <= '0;
                cur_page  <= cmd_page;
                src_slot  <= 1'b0;
                pend_mask <= pend_mask & ~cmd_oh;
                bad_acc   <= cmd_bad ? cmd_oh : '0;
                incons_q  <= |(col_mis & pend_mask & ~cmd_oh);
              end
              OP_ERASE_SETUP: begin
                if (prev_cmd == OP_ERASE_SETUP) begin
                  slot_page[cmd_pl] <= cmd_page;
                  pend_mask         <= pend_mask | cmd_oh;
                end
              end
              OP_ERASE_GO: begin
                if (prev_cmd == OP_ERASE_SETUP) begin
                  st        <= ST_ERASE;
                  cnt       <= '0;
                  cur_page  <= cmd_page;
                  pend_mask <= pend_mask & ~cmd_oh;
                  bad_acc   <= cmd_bad ? cmd_oh : '0;
                end else begin
                  fail_q    <= 1'b1;
                  pend_mask <= '0;
                end
              end
              default: ;
            endcase
          end
        end
        ST_COPY: begin
          if (page_last) st <= ST_IDLE;
          else           cnt <= cnt + 1'b1;
        end
        ST_PROG, ST_ERASE: begin
          if ((st == ST_PROG && page_last) || (st == ST_ERASE && erase_last)) begin
            if (nxt_any) begin
              pend_mask <= pend_mask & ~nxt_oh;
              cur_page  <= nxt_page;
              src_slot  <= 1'b1;
              src_pl    <= nxt_pl;
              bad_acc   <= bad_acc | (nxt_bad ? nxt_oh : '0);
              cnt       <= '0;
            end else begin
              st     <= ST_IDLE;
              fail_q <= |bad_acc;
              mp_bad <= bad_acc;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (st != ST_IDLE);
  assign status    = {1'b1, ~busy, 5'b00000, fail_q};
  assign mp_status = status | (8'(mp_bad) << 1);
  assign incons    = incons_q;

  // Assertions
  AST_ERASE_ONLY_FF: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ERASE) |-> (arr_we && arr_wdata == 8'hFF)); // R3

  AST_PROG_NEVER_SETS: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PROG && arr_we) |-> ((arr_wdata & ~arr_old) == 8'h00)); // R2

  AST_MASK_DRAINED: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_IDLE) && ($past(st) == ST_PROG || $past(st) == ST_ERASE)) |-> (pend_mask == '0)); // R4

  AST_FAIL_MATCHES_BAD: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_IDLE) && ($past(st) == ST_PROG || $past(st) == ST_ERASE)) |-> (fail_q == (|mp_bad))); // R7

  AST_STALE_GO_FAILS: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && st == ST_IDLE && cmd_code == OP_ERASE_GO && prev_cmd != OP_ERASE_SETUP)
    |=> (fail_q && st == ST_IDLE && pend_mask == '0)); // R6

  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && st != ST_IDLE) |=> $stable(prev_cmd)); // R9
endmodule

// File: tb/mp_flash_engine_bench.sv
`timescale 1ns/1ps
module mp_flash_engine_bench;
  localparam int PB    = 8;
  localparam int PAGES = 256;

  logic       clk = 1'b0;
  logic       rst;
  logic       cmd_valid;
  logic [7:0] cmd_code;
  logic [7:0] cmd_page;
  logic [7:0] cmd_col;
  logic       wb_we;
  logic [2:0] wb_idx;
  logic [7:0] wb_data;
  logic       bb_we;
  logic [2:0] bb_blk;
  logic       bb_mark;
  logic [7:0] rd_page;
  logic [2:0] rd_idx;
  logic [7:0] rd_data;
  logic       busy;
  logic [7:0] status;
  logic [7:0] mp_status;
  logic       incons;

  int checks = 0;
  int errors = 0;

  logic [7:0] model [PAGES*PB];
  logic [7:0] wbm   [PB];
  logic [7:0] stage [4][PB];

  always #2 clk = ~clk;

  mp_flash_engine u_mp_flash_engine (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_page(cmd_page), .cmd_col(cmd_col), .wb_we(wb_we), .wb_idx(wb_idx),
    .wb_data(wb_data), .bb_we(bb_we), .bb_blk(bb_blk), .bb_mark(bb_mark),
    .rd_page(rd_page), .rd_idx(rd_idx), .rd_data(rd_data), .busy(busy),
    .status(status), .mp_status(mp_status), .incons(incons)
  );

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'(seed * 37 + i * 29) ^ 8'(i << 4);
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", what, act, exp);
    end
  endtask

  task automatic drive_cmd(input logic [7:0] code, input logic [7:0] page, input logic [7:0] col);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = code; cmd_page = page; cmd_col = col;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic issue(input logic [7:0] code, input logic [7:0] page, input logic [7:0] col);
    drive_cmd(code, page, col);
    wait_idle();
  endtask

  task automatic load_wbuf(input int seed);
    for (int i = 0; i < PB; i++) begin
      @(negedge clk);
      wbm[i] = pat(seed, i);
      wb_we = 1'b1; wb_idx = 3'(i); wb_data = wbm[i];
    end
    @(negedge clk);
    wb_we = 1'b0;
  endtask

  task automatic set_bad(input int blk, input logic mark);
    @(negedge clk);
    bb_we = 1'b1; bb_blk = 3'(blk); bb_mark = mark;
    @(negedge clk);
    bb_we = 1'b0;
  endtask

  task automatic m_prog_wb(input int page);
    for (int i = 0; i < PB; i++) model[page*PB+i] &= wbm[i];
  endtask

  task automatic m_prog_stage(input int page);
    for (int i = 0; i < PB; i++) model[page*PB+i] &= stage[(page >> 5) & 3][i];
  endtask

  task automatic m_stage(input int page);
    for (int i = 0; i < PB; i++) stage[(page >> 5) & 3][i] = wbm[i];
  endtask

  task automatic m_erase(input int blk);
    for (int i = 0; i < 32*PB; i++) model[blk*32*PB+i] = 8'hFF;
  endtask

  task automatic check_page(input int page, input string tag);
    for (int i = 0; i < PB; i++) begin
      @(negedge clk);
      rd_page = 8'(page); rd_idx = 3'(i);
      @(negedge clk);
      chk(rd_data, model[page*PB+i], $sformatf("%s page %02h byte %0d", tag, page, i));
    end
  endtask

  task automatic t_reset();
    chk({7'd0, busy}, 8'h00, "R1 busy after reset");
    chk(status, 8'hC0, "R1 status after reset");
    chk(mp_status, 8'hC0, "R1 mp_status after reset");
    chk({7'd0, incons}, 8'h00, "R1 incons after reset");
  endtask

  task automatic t_erase_all();
    for (int b = 0; b < 8; b++) begin
      issue(8'h60, 8'(b*32), 8'h00);
      issue(8'hD0, 8'(b*32), 8'h00);
      m_erase(b);
      chk(status, 8'hC0, "R11 cleared bitmap gives pass on erase");
    end
    check_page(0, "R3");
    check_page(31, "R3");
    check_page(255, "R3");
  endtask

  task automatic t_single_program();
    load_wbuf(1);
    issue(8'h10, 8'h05, 8'h00);
    m_prog_wb(5);
    chk(status, 8'hC0, "R2 status after program");
    check_page(5, "R2 first program");
    load_wbuf(2);
    issue(8'h10, 8'h05, 8'h00);
    m_prog_wb(5);
    check_page(5, "R2 AND with second buffer");
    check_page(4, "R2 neighbour untouched");
  endtask

  task automatic t_stale_erase();
    issue(8'hD0, 8'h05, 8'h00);
    chk(status, 8'hC1, "R6 stale erase sets fail");
    check_page(5, "R6 stale erase leaves data");
    issue(8'h60, 8'hE0, 8'h00);
    issue(8'hD0, 8'hE0, 8'h00);
    m_erase(7);
    chk(status, 8'hC0, "R6 proper erase clears fail");
  endtask

  task automatic t_mp_program();
    load_wbuf(3);
    issue(8'h11, 8'h23, 8'h04);
    m_stage(8'h23);
    load_wbuf(4);
    issue(8'h11, 8'h43, 8'h04);
    m_stage(8'h43);
    load_wbuf(5);
    drive_cmd(8'h10, 8'h63, 8'h04);
    chk({7'd0, busy}, 8'h01, "R8 busy during commit");
    chk(status, 8'h80, "R8 ready low during commit");
    wait_idle();
    m_prog_wb(8'h63);
    m_prog_stage(8'h23);
    m_prog_stage(8'h43);
    chk(status, 8'hC0, "R4 status after multiplane program");
    chk({7'd0, incons}, 8'h00, "R10 matching columns");
    check_page(8'h63, "R4 addressed page");
    check_page(8'h23, "R4 staged plane 1");
    check_page(8'h43, "R4 staged plane 2");
  endtask

  task automatic t_busy_ignore();
    load_wbuf(6);
    drive_cmd(8'h10, 8'h08, 8'h00);
    drive_cmd(8'hD0, 8'h08, 8'h00);
    wait_idle();
    m_prog_wb(8);
    chk(status, 8'hC0, "R9 command while busy ignored");
    check_page(8, "R9 program unaffected");
  endtask

  task automatic t_bad_erase();
    set_bad(2, 1'b1);
    issue(8'h60, 8'h00, 8'h00);
    issue(8'h60, 8'h20, 8'h00);
    issue(8'hD0, 8'h40, 8'h00);
    m_erase(1);
    m_erase(2);
    chk(status, 8'hC1, "R7 bad block fails erase");
    chk(mp_status, 8'hC9, "R7 plane 2 bit in mp status");
    check_page(8'h23, "R5 staged block erased");
    check_page(8'h43, "R5 addressed block erased");
    check_page(8'h5F, "R5 last page of block");
    check_page(8'h63, "R5 other block kept");
  endtask

  task automatic t_bad_program();
    set_bad(4, 1'b1);
    set_bad(2, 1'b0);
    load_wbuf(7);
    issue(8'h10, 8'h80, 8'h00);
    m_prog_wb(8'h80);
    chk(status, 8'hC1, "R7 program on bad block");
    chk(mp_status, 8'hC3, "R8 plane 0 bit in mp status");
    check_page(8'h80, "R7 bad block still written");
    load_wbuf(8);
    issue(8'h10, 8'h41, 8'h00);
    m_prog_wb(8'h41);
    chk(status, 8'hC0, "R11 unmarked block passes");
    chk(mp_status, 8'hC0, "R11 mp status clear");
  endtask

  task automatic t_incons();
    load_wbuf(9);
    issue(8'h11, 8'h2A, 8'h01);
    m_stage(8'h2A);
    load_wbuf(10);
    issue(8'h10, 8'h6A, 8'h02);
    m_prog_wb(8'h6A);
    m_prog_stage(8'h2A);
    chk({7'd0, incons}, 8'h01, "R10 column mismatch flagged");
    check_page(8'h6A, "R10 commit proceeds");
    check_page(8'h2A, "R10 staged commit proceeds");
    load_wbuf(11);
    issue(8'h10, 8'h0A, 8'h02);
    m_prog_wb(8'h0A);
    chk({7'd0, incons}, 8'h00, "R10 flag cleared");
    check_page(8'h0A, "R2 single page");
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL R1 watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    cmd_valid = 1'b0; cmd_code = '0; cmd_page = '0; cmd_col = '0;
    wb_we = 1'b0; wb_idx = '0; wb_data = '0;
    bb_we = 1'b0; bb_blk = '0; bb_mark = 1'b0;
    rd_page = '0; rd_idx = '0;
    for (int i = 0; i < PAGES*PB; i++) model[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_erase_all();
    t_single_program();
    t_stale_erase();
    t_mp_program();
    t_busy_ignore();
    t_bad_erase();
    t_bad_program();
    t_incons();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule